// File: doc/BRIEF.md
# Column Line Latch with Polarity-Dependent Output State

This block sits between the column data register of a display column driver and its output stage. A strobe marks each horizontal line. When the strobe rises, the block copies a full line of gray-scale codes from the data register into a line latch and samples the polarity input. When the strobe falls, it presents the latched codes to the output channels. At the same time it sets, for each channel, which half of the reference ladder that channel uses. Odd and even columns always take opposite halves, and the polarity decides which column gets which half.

While the strobe is high, no channel drives. Each output is either held in reset or left floating. The choice depends on whether the polarity just sampled differs from the one sampled on the previous line. The strobe is sampled on the system clock, so both of its edges are seen as synchronous events. One strobe pulse is expected per line.

Top module: `col_line_latch`

## Requirements
- R1: After reset, every channel's state is high impedance (code 2'b00), all code outputs are zero, and the stored polarity is low, so channel 0 has `upper_o` = 0 and channel 1 has `upper_o` = 1.
- R2: The clock edge on which `stb` is first seen high copies `line_data` into the line latch. Later changes to `line_data` do not alter the codes shown after the strobe falls.
- R3: The clock edge on which `stb` is first seen low after being high sets every channel's state to drive (2'b01) and loads `code_o` with the latched codes. Channel i occupies bits [8i+7:8i].
- R4: Channel i with even index (an odd-numbered column) has `upper_o[i]` equal to the polarity sampled at the strobe's rise, and channel i with odd index has the inverse. Here 1 selects the upper reference set (levels 8 to 15) and 0 selects the lower set (levels 0 to 7).
- R5: From the strobe's rising clock edge until its falling clock edge, if the sampled polarity differs from the previous sampled polarity, every channel's state is reset (2'b10).
- R6: In the same window, if the sampled polarity equals the previous sampled polarity, every channel's state is high impedance (2'b00).
- R7: `code_o` and `upper_o` change only on the strobe's falling clock edge and hold their values at all other times.
- R8: The state code 2'b11 never appears, and all channels carry the same state.
- R9: Changes to `pol` while the strobe is high have no effect. Only the value sampled at the rising edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stb | input | 1 | Line strobe, synchronous to clk |
| pol | input | 1 | Polarity for the next line |
| line_data | input | NCH*CW | Data register contents, channel i at [CW*i +: CW] |
| code_o | output | NCH*CW | Gray-scale code per channel |
| upper_o | output | NCH | Reference half select per channel, 1 = upper set |
| state_o | output | 2*NCH | Drive state per channel: 00 high-Z, 01 drive, 10 reset |

## Verification
The bench walks the strobe through every polarity transition: unchanged low from reset, low to high, unchanged high, and high to low. It checks the reset-versus-floating choice in each case, so a design that compares against the wrong line's polarity, or that drives during the strobe, fails. Inside the strobe window it changes both `line_data` and `pol`. A design that latches on the wrong edge, or that follows polarity continuously, then shows the wrong codes or swapped halves. Random lines with random strobe widths and gaps confirm that codes and halves hold between falling edges and alternate correctly across odd and even channels.

// File: rtl/col_line_latch.sv
module col_line_latch #(
  parameter int NCH = 8,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              pol,
  input  logic [NCH*CW-1:0] line_data,
  output logic [NCH*CW-1:0] code_o,
  output logic [NCH-1:0]    upper_o,
  output logic [2*NCH-1:0]  state_o
);
  localparam int LW = NCH * CW;
  localparam logic [1:0] ST_HIZ = 2'b00;
  localparam logic [1:0] ST_DRV = 2'b01;
  localparam logic [1:0] ST_RST = 2'b10;

  logic          stb_q, pol_line, drv_pol;
  logic [1:0]    st;
  logic [LW-1:0] latch_q;

  wire stb_rise = stb & ~stb_q;
  wire stb_fall = ~stb & stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q    <= 1'b0;
      pol_line <= 1'b0;
      drv_pol  <= 1'b0;
      st       <= ST_HIZ;
      latch_q  <= '0;
      code_o   <= '0;
    end else begin
      stb_q <= stb;
      if (stb_rise) begin
        latch_q  <= line_data;
        pol_line <= pol;
        st       <= (pol != pol_line) ? ST_RST : ST_HIZ;
      end
      if (stb_fall) begin
        code_o  <= latch_q;
        drv_pol <= pol_line;
        st      <= ST_DRV;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign upper_o[i]       = drv_pol ^ ((i % 2) != 0);
    assign state_o[2*i +: 2] = st;
  end

  a_r5_no_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> state_o[1:0] != ST_DRV);
  a_r5_reset_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && (pol != pol_line)) |=> state_o[1:0] == ST_RST);
  a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> state_o[1:0] == ST_DRV);
  a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_fall |=> ($stable(code_o) && $stable(upper_o)));
  a_r8_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    state_o[2*NCH-1 -: 2] != 2'b11);
endmodule

// File: tb/test_col_line_latch.sv
module test_col_line_latch;
  localparam int NCH = 8;
  localparam int CW  = 8;
  localparam int LW  = NCH * CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stb = 1'b0;
  logic          pol = 1'b0;
  logic [LW-1:0] line_data = '0;
  logic [LW-1:0] code_o;
  logic [NCH-1:0] upper_o;
  logic [2*NCH-1:0] state_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic          prev_pol = 1'b0;
  logic          shown_pol = 1'b0;
  logic [LW-1:0] shown_code = '0;

  always #2.5 clk = ~clk;

  col_line_latch #(.NCH(NCH), .CW(CW)) i_col_line_latch (
    .clk(clk), .rst_n(rst_n), .stb(stb), .pol(pol), .line_data(line_data),
    .code_o(code_o), .upper_o(upper_o), .state_o(state_o));

  function automatic logic [2*NCH-1:0] all_state(input logic [1:0] s);
    return {NCH{s}};
  endfunction

  function automatic logic [NCH-1:0] exp_upper(input logic p);
    logic [NCH-1:0] u;
    for (int i = 0; i < NCH; i++) u[i] = p ^ (i % 2 == 1);
    return u;
  endfunction

  function automatic logic [LW-1:0] rand_line();
    logic [LW-1:0] v;
    for (int i = 0; i < LW / 32 + 1; i++) v = {v, $urandom()};
    return v;
  endfunction

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_held(input string req);
    chk(req, code_o, shown_code);
    chk(req, LW'(upper_o), LW'(exp_upper(shown_pol)));
  endtask

  task automatic run_line(input logic p, input int hi_cycles, input int gap);
    logic [LW-1:0] d;
    logic [1:0] exp_st;
    d = rand_line();
    @(negedge clk);
    stb = 1'b1; pol = p; line_data = d;
    exp_st = (p != prev_pol) ? 2'b10 : 2'b00;
    @(negedge clk);
    chk(exp_st == 2'b10 ? "R5 reset state" : "R6 hiz state", LW'(state_o), LW'(all_state(exp_st)));
    check_held("R7 hold at rise");
    line_data = rand_line(); pol = ~p;
    for (int k = 1; k < hi_cycles; k++) begin
      @(negedge clk);
      chk("R8 state during strobe", LW'(state_o), LW'(all_state(exp_st)));
    end
    stb = 1'b0;
    @(negedge clk);
    chk("R3 drive state", LW'(state_o), LW'(all_state(2'b01)));
    chk("R2 latched codes", code_o, d);
    chk("R4 R9 reference halves", LW'(upper_o), LW'(exp_upper(p)));
    prev_pol = p; shown_pol = p; shown_code = d;
    line_data = rand_line(); pol = $urandom_range(0, 1);
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      check_held("R7 hold between lines");
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", LW'(state_o), '0);
    chk("R1 reset codes", code_o, '0);
    chk("R1 reset halves", LW'(upper_o), LW'(exp_upper(1'b0)));
    run_line(1'b0, 1, 2);
    run_line(1'b1, 3, 1);
    run_line(1'b1, 2, 0);
    run_line(1'b0, 1, 3);
    run_line(1'b0, 4, 1);
    for (int n = 0; n < 30; n++)
      run_line(1'($urandom_range(0, 1)), $urandom_range(1, 5), $urandom_range(0, 4));
    done = 1;
    finish_up();
  end
endmodule